// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block collects up to 32 level-sensitive interrupt lines and names the one to service next. Software gives each line four attributes through a small register port: an enable, a priority level, a register-set number and a non-maskable flag. Each cycle, selection logic picks the strongest line that is both pending and enabled. A vector stage then forms a handler address from a programmable base, the line number and a programmable power-of-two spacing.

The result leaves the block as a registered record: valid, handler address, level, register set and non-maskable flag. An input of the same record shape lets several controllers be chained. The record from an upstream controller competes with the local winner, and the stronger of the two is passed on. A processor, or the next controller downstream, consumes the output record.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every line is disabled with all-zero attributes, the vector base is 0, the spacing exponent is 2, and `out_valid` is 0.
- R2: A source configuration word sits at register address i for line i (0..NUM_IRQ-1). Its layout is: bit 0 enable, bit 1 non-maskable, bits 13:8 level, bits 21:16 register set. All other bits read as 0. Read data appears on `csr_rdata` one cycle after `csr_rd` is sampled.
- R3: Address NUM_IRQ+2 reads the raw `irq_in` lines whether or not they are enabled. Writes to this address change nothing.
- R4: A pending line whose enable bit is 0 never produces or influences an output record.
- R5: A non-maskable request beats any maskable one. Within the same class, the higher level wins, and on equal level the lower line index wins.
- R6: The handler address is base + index × 2^S. The base is the full word at address NUM_IRQ. S is bits 3:0 of address NUM_IRQ+1, and a write below 2 stores 2 while a write above 9 stores 9.
- R7: A record that comes from a local line carries that line's level, register set and non-maskable flag.
- R8: The output record is registered. `out_valid` is 1 in the cycle after a cycle in which any enabled line was pending or `chain_valid` was 1.
- R9: A valid chained record is passed on unchanged when no enabled line is pending, or when its {non-maskable, level} key is strictly greater than the local winner's key. On an equal key the local winner is passed on.
- R10: While `out_valid` is 0, the address, level, register set and non-maskable outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_IRQ | Level-sensitive interrupt lines |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | CSR_AW | Register word address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, one cycle after the read strobe |
| chain_valid | input | 1 | Upstream record valid |
| chain_addr | input | 32 | Upstream handler address |
| chain_level | input | 6 | Upstream level |
| chain_rset | input | 6 | Upstream register set |
| chain_nmi | input | 1 | Upstream non-maskable flag |
| out_valid | output | 1 | Output record valid |
| out_addr | output | 32 | Selected handler address |
| out_level | output | 6 | Selected level |
| out_rset | output | 6 | Selected register set |
| out_nmi | output | 1 | Selected non-maskable flag |

## Verification
Every piece of state in this block reaches the ports within one cycle. A stored enable, level or flag that is wrong changes which handler address appears in the record on the clock after the lines are driven. A corrupted base or spacing exponent moves the address by a visible multiple. A bad merge decision shows up as an upstream address where the local one should be, or the other way round. The bench therefore drives crafted line patterns and chained records and compares each full record one cycle later. It also reads every register field back through the register port.

// File: rtl/vic_pkg.sv
// Package: shared widths, register layout and helper functions for the
// vectored interrupt controller. Assumes 32-bit register words.
package vic_pkg;
    localparam int WORD_W    = 32;
    localparam int LVL_W     = 6;
    localparam int RSET_W    = 6;
    localparam int HADDR_W   = 32;
    localparam int SHIFT_W   = 4;
    localparam int SHIFT_MIN = 2;
    localparam int SHIFT_MAX = 9;
    localparam int KEY_W     = LVL_W + 1;

    // Bit positions inside a source configuration word
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_NMI_BIT  = 1;
    localparam int CFG_LVL_LSB  = 8;
    localparam int CFG_RSET_LSB = 16;

    typedef struct packed {
        logic              en;
        logic              nmi;
        logic [LVL_W-1:0]  lvl;
        logic [RSET_W-1:0] rset;
    } src_cfg_t;

    // Limit a written spacing exponent to the supported range
    function automatic logic [SHIFT_W-1:0] clamp_shift(input logic [WORD_W-1:0] v);
        if (v < WORD_W'(SHIFT_MIN))      return SHIFT_W'(SHIFT_MIN);
        else if (v > WORD_W'(SHIFT_MAX)) return SHIFT_W'(SHIFT_MAX);
        else                             return v[SHIFT_W-1:0];
    endfunction

    // Place a source configuration into its register word layout
    function automatic logic [WORD_W-1:0] pack_cfg(input src_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CFG_EN_BIT]                  = c.en;
        w[CFG_NMI_BIT]                 = c.nmi;
        w[CFG_LVL_LSB +: LVL_W]        = c.lvl;
        w[CFG_RSET_LSB +: RSET_W]      = c.rset;
        return w;
    endfunction

    // Extract a source configuration from a written word
    function automatic src_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        src_cfg_t c;
        c.en   = w[CFG_EN_BIT];
        c.nmi  = w[CFG_NMI_BIT];
        c.lvl  = w[CFG_LVL_LSB +: LVL_W];
        c.rset = w[CFG_RSET_LSB +: RSET_W];
        return c;
    endfunction
endpackage

// File: rtl/vic_regs.sv
// Register bank: one configuration word per line, vector base, spacing
// exponent and a read-only view of the raw lines. Assumes single-cycle
// strobes; read data is registered.
module vic_regs
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int CSR_AW  = $clog2(NUM_IRQ + 3)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_wr,
    input  logic                csr_rd,
    input  logic [CSR_AW-1:0]   csr_addr,
    input  logic [WORD_W-1:0]   csr_wdata,
    output logic [WORD_W-1:0]   csr_rdata,
    input  logic [NUM_IRQ-1:0]  irq_in,
    output src_cfg_t            cfg [NUM_IRQ],
    output logic [HADDR_W-1:0]  vec_base,
    output logic [SHIFT_W-1:0]  vec_shift
);
    localparam logic [CSR_AW-1:0] A_BASE  = CSR_AW'(NUM_IRQ);
    localparam logic [CSR_AW-1:0] A_SHIFT = CSR_AW'(NUM_IRQ + 1);
    localparam logic [CSR_AW-1:0] A_PEND  = CSR_AW'(NUM_IRQ + 2);

    logic [WORD_W-1:0] rd_mux;

    // Per-line configuration storage
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)                                  cfg[i] <= '0;
            else if (csr_wr && csr_addr == CSR_AW'(i))   cfg[i] <= unpack_cfg(csr_wdata);
        end
    end

    // Vector base and spacing exponent storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base  <= '0;
            vec_shift <= SHIFT_W'(SHIFT_MIN);
        end else if (csr_wr) begin
            if (csr_addr == A_BASE)  vec_base  <= csr_wdata[HADDR_W-1:0];
            if (csr_addr == A_SHIFT) vec_shift <= clamp_shift(csr_wdata);
        end
    end

    // Read multiplexer over all mapped words
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_IRQ; i++)
            if (csr_addr == CSR_AW'(i)) rd_mux = pack_cfg(cfg[i]);
        if (csr_addr == A_BASE)  rd_mux = WORD_W'(vec_base);
        if (csr_addr == A_SHIFT) rd_mux = WORD_W'(vec_shift);
        if (csr_addr == A_PEND)  rd_mux = WORD_W'(irq_in);
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      csr_rdata <= '0;
        else if (csr_rd) csr_rdata <= rd_mux;
    end
endmodule

// File: rtl/vic_arbiter.sv
// Priority selection among pending, enabled lines. Key is {nmi, level};
// a strictly larger key replaces the current choice, so ties keep the
// lower index. Purely combinational.
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] irq_in,
    input  src_cfg_t           cfg [NUM_IRQ],
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output logic [KEY_W-1:0]   win_key,
    output logic [RSET_W-1:0]  win_rset
);
    // Ascending scan keeping the strongest request seen so far
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_key   = '0;
        win_rset  = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (irq_in[i] && cfg[i].en &&
                (!win_valid || {cfg[i].nmi, cfg[i].lvl} > win_key)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_key   = {cfg[i].nmi, cfg[i].lvl};
                win_rset  = cfg[i].rset;
            end
        end
    end
endmodule

// File: rtl/vic_vector.sv
// Handler address generation: base plus index scaled by 2^shift.
// Assumes shift is already limited to the supported range.
module vic_vector
    import vic_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [HADDR_W-1:0] base,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [IDX_W-1:0]   idx,
    output logic [HADDR_W-1:0] addr
);
    // Scaled offset added to the base
    always_comb addr = base + (HADDR_W'(idx) << shift);
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top: register bank, arbiter and vector stage, then a merge with the
// chained upstream record and a registered output record. Fields are
// forced to zero whenever no record is valid.
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int CSR_AW  = $clog2(NUM_IRQ + 3)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IRQ-1:0]       irq_in,
    input  logic                     csr_wr,
    input  logic                     csr_rd,
    input  logic [CSR_AW-1:0]        csr_addr,
    input  logic [vic_pkg::WORD_W-1:0]  csr_wdata,
    output logic [vic_pkg::WORD_W-1:0]  csr_rdata,
    input  logic                     chain_valid,
    input  logic [vic_pkg::HADDR_W-1:0] chain_addr,
    input  logic [vic_pkg::LVL_W-1:0]   chain_level,
    input  logic [vic_pkg::RSET_W-1:0]  chain_rset,
    input  logic                     chain_nmi,
    output logic                     out_valid,
    output logic [vic_pkg::HADDR_W-1:0] out_addr,
    output logic [vic_pkg::LVL_W-1:0]   out_level,
    output logic [vic_pkg::RSET_W-1:0]  out_rset,
    output logic                     out_nmi
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    src_cfg_t           cfg [NUM_IRQ];
    logic [HADDR_W-1:0] vec_base;
    logic [SHIFT_W-1:0] vec_shift;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic [KEY_W-1:0]   win_key;
    logic [RSET_W-1:0]  win_rset;
    logic [HADDR_W-1:0] win_addr;
    logic               take_local;
    logic               nxt_valid;
    logic [HADDR_W-1:0] nxt_addr;
    logic [LVL_W-1:0]   nxt_level;
    logic [RSET_W-1:0]  nxt_rset;
    logic               nxt_nmi;

    vic_regs #(.NUM_IRQ(NUM_IRQ), .CSR_AW(CSR_AW)) u_regs (
        .clk, .rst_n, .csr_wr, .csr_rd, .csr_addr, .csr_wdata, .csr_rdata,
        .irq_in, .cfg, .vec_base, .vec_shift
    );

    vic_arbiter #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_arb (
        .irq_in, .cfg, .win_valid, .win_idx, .win_key, .win_rset
    );

    vic_vector #(.IDX_W(IDX_W)) u_vec (
        .base(vec_base), .shift(vec_shift), .idx(win_idx), .addr(win_addr)
    );

    // Merge local winner with chained record; local keeps equal keys
    always_comb begin
        take_local = win_valid && (!chain_valid || win_key >= {chain_nmi, chain_level});
        nxt_valid  = win_valid || chain_valid;
        nxt_addr   = '0;
        nxt_level  = '0;
        nxt_rset   = '0;
        nxt_nmi    = 1'b0;
        if (take_local) begin
            nxt_addr  = win_addr;
            nxt_level = win_key[LVL_W-1:0];
            nxt_rset  = win_rset;
            nxt_nmi   = win_key[KEY_W-1];
        end else if (chain_valid) begin
            nxt_addr  = chain_addr;
            nxt_level = chain_level;
            nxt_rset  = chain_rset;
            nxt_nmi   = chain_nmi;
        end
    end

    // Output record register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_level <= '0;
            out_rset  <= '0;
            out_nmi   <= 1'b0;
        end else begin
            out_valid <= nxt_valid;
            out_addr  <= nxt_addr;
            out_level <= nxt_level;
            out_rset  <= nxt_rset;
            out_nmi   <= nxt_nmi;
        end
    end
endmodule

// File: rtl/vic_checker.sv
// Checker: temporal properties of the output record, bound to the top.
module vic_checker
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_in,
    input logic [NUM_IRQ-1:0] en_mask,
    input logic [SHIFT_W-1:0] vec_shift,
    input logic               chain_valid,
    input logic [HADDR_W-1:0] chain_addr,
    input logic [LVL_W-1:0]   chain_level,
    input logic [RSET_W-1:0]  chain_rset,
    input logic               chain_nmi,
    input logic               out_valid,
    input logic [HADDR_W-1:0] out_addr,
    input logic [LVL_W-1:0]   out_level,
    input logic [RSET_W-1:0]  out_rset,
    input logic               out_nmi
);
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past((|(irq_in & en_mask)) || chain_valid));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_addr == '0 && out_level == '0 && out_rset == '0 && !out_nmi));

    assert_shift_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_shift >= SHIFT_W'(SHIFT_MIN) && vec_shift <= SHIFT_W'(SHIFT_MAX));

    assert_chain_nmi_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_valid && chain_nmi) |=> (out_valid && out_nmi));

    assert_chain_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_valid && !(|(irq_in & en_mask))) |=>
        (out_addr == $past(chain_addr) && out_level == $past(chain_level) &&
         out_rset == $past(chain_rset) && out_nmi == $past(chain_nmi)));

    assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_valid && !(|(irq_in & en_mask))) |=> !out_valid);
endmodule

module vic_en_tap
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  src_cfg_t           cfg [NUM_IRQ],
    output logic [NUM_IRQ-1:0] en_mask
);
    // Gather enable bits into one vector for the checker
    always_comb for (int i = 0; i < NUM_IRQ; i++) en_mask[i] = cfg[i].en;
endmodule

bind irq_vector_ctrl vic_en_tap #(.NUM_IRQ(NUM_IRQ)) u_en_tap (
    .cfg(cfg), .en_mask()
);

bind irq_vector_ctrl vic_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .en_mask(u_en_tap.en_mask),
    .vec_shift(vec_shift), .chain_valid(chain_valid), .chain_addr(chain_addr),
    .chain_level(chain_level), .chain_rset(chain_rset), .chain_nmi(chain_nmi),
    .out_valid(out_valid), .out_addr(out_addr), .out_level(out_level),
    .out_rset(out_rset), .out_nmi(out_nmi)
);

// File: tb/irq_vector_ctrl_test.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_vector_ctrl_test;
    localparam int N   = 32;
    localparam int AW  = $clog2(N + 3);
    localparam int A_BASE  = N;
    localparam int A_SHIFT = N + 1;
    localparam int A_PEND  = N + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          csr_wr = 1'b0, csr_rd = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic          chain_valid = 1'b0;
    logic [31:0]   chain_addr = '0;
    logic [5:0]    chain_level = '0;
    logic [5:0]    chain_rset = '0;
    logic          chain_nmi = 1'b0;
    logic          out_valid;
    logic [31:0]   out_addr;
    logic [5:0]    out_level;
    logic [5:0]    out_rset;
    logic          out_nmi;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl uut (
        .clk, .rst_n, .irq_in, .csr_wr, .csr_rd, .csr_addr, .csr_wdata, .csr_rdata,
        .chain_valid, .chain_addr, .chain_level, .chain_rset, .chain_nmi,
        .out_valid, .out_addr, .out_level, .out_rset, .out_nmi
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit en, input bit nmi, input int lvl, input int rs);
        return {10'd0, 6'(rs), 2'd0, 6'(lvl), 6'd0, nmi, en};
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = AW'(a); csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        csr_rd = 1'b1; csr_addr = AW'(a);
        @(negedge clk);
        csr_rd = 1'b0;
        d = csr_rdata;
    endtask

    // Drive lines/chain at a falling edge, sample after the next rising edge
    task automatic step(input logic [N-1:0] lines);
        @(negedge clk);
        irq_in = lines;
        @(negedge clk);
    endtask

    task automatic check_rec(input string req, input bit v, input logic [31:0] a,
                             input int lvl, input int rs, input bit nmi);
        check({req, " valid"}, 32'(out_valid), 32'(v));
        check({req, " addr"},  out_addr, a);
        check({req, " level"}, 32'(out_level), 32'(lvl));
        check({req, " rset"},  32'(out_rset), 32'(rs));
        check({req, " nmi"},   32'(out_nmi), 32'(nmi));
    endtask

    task automatic t_reset_R1;
        logic [31:0] d;
        check("R1 out_valid", 32'(out_valid), 0);
        rd(A_SHIFT, d); check("R1 shift", d, 2);
        rd(A_BASE, d);  check("R1 base", d, 0);
        rd(0, d);       check("R1 cfg0", d, 0);
        rd(N - 1, d);   check("R1 cfg last", d, 0);
    endtask

    task automatic t_cfg_R2;
        logic [31:0] d;
        wr(5, 32'hFFFF_FFFF);
        rd(5, d); check("R2 field mask", d, 32'h003F_3F03);
        wr(5, mk(0, 1, 9, 33));
        rd(5, d); check("R2 layout", d, mk(0, 1, 9, 33));
        wr(5, 0);
    endtask

    task automatic t_pending_R3_R4;
        logic [31:0] d;
        step(32'h0000_00A5);
        rd(A_PEND, d); check("R3 raw lines", d, 32'h0000_00A5);
        wr(A_PEND, 32'h0);
        rd(A_PEND, d); check("R3 write ignored", d, 32'h0000_00A5);
        check("R4 disabled no record", 32'(out_valid), 0);
        step('0);
    endtask

    task automatic t_vector_R6_R7_R8;
        logic [31:0] d;
        wr(A_BASE, 32'h0000_1000);
        wr(A_SHIFT, 4);
        wr(3, mk(1, 0, 5, 7));
        @(negedge clk);
        irq_in = 32'h8;
        #1 check("R8 not yet visible", 32'(out_valid), 0);
        @(negedge clk);
        check_rec("R6 R7 base+3*16", 1, 32'h0000_1030, 5, 7, 0);
        wr(A_SHIFT, 0);
        rd(A_SHIFT, d); check("R6 clamp low", d, 2);
        wr(A_SHIFT, 15);
        rd(A_SHIFT, d); check("R6 clamp high", d, 9);
        step(32'h8);
        check("R6 base+3*512", out_addr, 32'h0000_1600);
        step('0);
        check("R8 drop", 32'(out_valid), 0);
        wr(3, 0);
        wr(A_BASE, 0);
        wr(A_SHIFT, 2);
    endtask

    task automatic t_priority_R5_R4;
        wr(1, mk(1, 0, 3, 1));
        wr(2, mk(1, 0, 7, 2));
        wr(4, mk(1, 0, 7, 4));
        wr(6, mk(0, 1, 63, 6));
        step(32'h0000_0056);
        check_rec("R5 level then index", 1, 32'd8, 7, 2, 0);
        wr(0, mk(1, 1, 0, 3));
        step(32'h0000_0057);
        check_rec("R5 nmi first", 1, 32'd0, 0, 3, 1);
        step(32'h0000_0042);
        check_rec("R4 disabled nmi ignored", 1, 32'd4, 3, 1, 0);
    endtask

    task automatic t_chain_R9_R10;
        @(negedge clk);
        chain_valid = 1; chain_addr = 32'h0000_ABC0; chain_level = 10; chain_rset = 9; chain_nmi = 0;
        irq_in = 32'h4;
        @(negedge clk);
        check_rec("R9 chain higher", 1, 32'h0000_ABC0, 10, 9, 0);
        chain_level = 7;
        @(negedge clk);
        check_rec("R9 tie keeps local", 1, 32'd8, 7, 2, 0);
        chain_level = 1; chain_nmi = 1;
        @(negedge clk);
        check_rec("R9 chain nmi", 1, 32'h0000_ABC0, 1, 9, 1);
        irq_in = '0; chain_nmi = 0;
        @(negedge clk);
        check_rec("R9 pass through", 1, 32'h0000_ABC0, 1, 9, 0);
        chain_valid = 0;
        @(negedge clk);
        check_rec("R10 idle zero", 0, 32'd0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_R1;
        t_cfg_R2;
        t_pending_R3_R4;
        t_vector_R6_R7_R8;
        t_priority_R5_R4;
        t_chain_R9_R10;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #4_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule